// File: doc/BRIEF.md
# Configuration clock source selector

This block decides which clock runs an active-mode configuration controller: a free-running internal configuration oscillator or an external user clock pin. Single-cycle command pulses, all in the `ctl_clk` domain, ask for the user clock or for the oscillator. The changeover is glitch-free. Each clock has its own gating lane. The old lane is switched off and its shutdown is confirmed before the new lane is switched on, so the merged output `sel_clk` never carries a shortened pulse. A return to the oscillator is committed only after the user clock has run for a tail of further cycles. If the user clock stops, the block stays on the user clock indefinitely.

The block also decides when the oscillator has to stay powered. It handles a re-engage command: in an active scheme this restarts the controller and requests reconfiguration, and in a passive scheme it produces a configuration pulse. It masks the external configuration pin while such a command is handled. The controller, the test-port decoding and the bitstream path are outside this block. Only power-on reset clears the clock selection.

Top module: `cfg_clk_source_sel`

## Requirements
- R1: After power-on reset the committed source is the oscillator (`src_usr`=0). `sel_clk` then carries the oscillator clock. Asserting `por_n` low clears a user-clock selection at once.
- R2: A `cmd_use_usr` pulse, accepted while the oscillator is kept enabled, ends with `switching`=0 and `src_usr`=1. `sel_clk` then carries the user clock.
- R3: A request for the user clock is held without starting while the oscillator is not kept enabled. It starts once a keep condition appears.
- R4: A `cmd_use_osc` pulse commits the oscillator only after at least USR_TAIL (10) further `usr_clk` rising edges. While `usr_clk` is stopped, `src_usr` stays 1 and `switching` stays 1.
- R5: Falling or rising `cfg_pin_n` and pulses on `tap_rst` never change `src_usr`.
- R6: `osc_en` is 1 in the cycle after any of these holds: `user_mode`=0, `rmt_upd_en`=1, `err_det_en`=1, a reconfiguration pending, or a changeover running. Otherwise it is 0.
- R7: `cmd_reengage` with `scheme_active`=1 gives one-cycle pulses on `ctl_restart` and `reconfig_req`. Both appear in the cycle after the command.
- R8: `cmd_reengage` with `scheme_active`=0 drives `cfg_pulse` high for PULSE_LEN (8) cycles. It produces no `reconfig_req` and no `ctl_restart`.
- R9: `cfg_pin_mask` is high for PULSE_LEN cycles after any `cmd_reengage`, and a falling `cfg_pin_n` during that time is ignored. An unmasked falling `cfg_pin_n` gives a one-cycle `reconfig_req` in the next cycle.
- R10: Commands that arrive during a changeover are held and applied after it ends, and the last one wins. If both commands arrive in the same cycle, the oscillator wins.
- R11: The two gating lanes are never on together. `src_usr` changes only when a changeover completes.
- R12: `data_clk` toggles on each rising edge of `sel_clk`, which gives half its rate.
- R13: A `tap_rst` pulse aborts re-engage handling: `cfg_pin_mask` and `cfg_pulse` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock for commands and status |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_clk | input | 1 | Internal configuration oscillator |
| usr_clk | input | 1 | External user clock pin |
| cmd_use_usr | input | 1 | Pulse: select the user clock |
| cmd_use_osc | input | 1 | Pulse: return to the oscillator |
| cmd_reengage | input | 1 | Pulse: re-engage the configuration controller |
| cfg_pin_n | input | 1 | External configuration pin, low requests reconfiguration |
| tap_rst | input | 1 | Test-controller reset pulse |
| scheme_active | input | 1 | 1 = active scheme, 0 = passive scheme |
| user_mode | input | 1 | Device has entered user mode |
| rmt_upd_en | input | 1 | Remote update enabled |
| err_det_en | input | 1 | Error detection enabled |
| sel_clk | output | 1 | Selected, glitch-free configuration clock |
| data_clk | output | 1 | Selected clock divided by two |
| osc_en | output | 1 | Keep the oscillator powered |
| src_usr | output | 1 | Committed source: 1 = user clock |
| switching | output | 1 | A changeover is in progress |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| ctl_restart | output | 1 | One-cycle controller restart |
| cfg_pulse | output | 1 | Configuration pulse in a passive scheme |
| cfg_pin_mask | output | 1 | Configuration pin is being ignored |

## Verification
The assertions check the cycle-level rules on every cycle. They cover the two lanes never being on together, the committed source changing only at the end of a changeover, the keep conditions forcing `osc_en`, the masked pin never raising a request, and re-engage outputs matching the scheme. Other behaviours only the bench scenarios can show. These are the held user-clock request, the 10-cycle tail measured in user-clock edges, a stalled return while the user clock is stopped, last-command-wins ordering, and the selection surviving pin toggles and test resets.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DROP  = 2'd1,
        PH_RAISE = 2'd2
    } phase_t;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_USR = 1'b1
    } src_t;

    localparam int LANES    = 2;
    localparam int LANE_OSC = 0;
    localparam int LANE_USR = 1;
endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/ccs_lane.sv
`timescale 1ns/1ps
module ccs_lane #(
    parameter int HOLD   = 0,
    parameter int STAGES = 2
) (
    input  logic lane_clk,
    input  logic por_n,
    input  logic req,
    output logic on,
    output logic gclk
);
    logic req_s;
    logic en_q;
    logic on_q;

    ccs_sync #(.W(1), .STAGES(STAGES)) u_req (
        .clk  (lane_clk),
        .rst_n(por_n),
        .d    (req),
        .q    (req_s)
    );

    generate
        if (HOLD == 0) begin : g_direct
            always_ff @(posedge lane_clk or negedge por_n) begin
                if (!por_n) en_q <= 1'b0;
                else        en_q <= req_s;
            end
        end else begin : g_tail
            localparam int CW = $clog2(HOLD + 1);
            typedef struct packed {
                logic          en;
                logic [CW-1:0] cnt;
            } tail_t;
            tail_t t_d, t_q;

            always_comb begin
                t_d = t_q;
                if (req_s) begin
                    t_d.en  = 1'b1;
                    t_d.cnt = '0;
                end else if (t_q.en) begin
                    if (t_q.cnt == CW'(HOLD - 1)) begin
                        t_d.en  = 1'b0;
                        t_d.cnt = '0;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
            end

            always_ff @(posedge lane_clk or negedge por_n) begin
                if (!por_n) t_q <= '0;
                else        t_q <= t_d;
            end

            assign en_q = t_q.en;

            // R4: the tail counter never runs past its window
            assert_tail_bound_R4: assert property (
                @(posedge lane_clk) disable iff (!por_n)
                int'(t_q.cnt) < HOLD
            );
        end
    endgenerate

    // gate changes only while the lane clock is low
    always_ff @(negedge lane_clk or negedge por_n) begin
        if (!por_n) on_q <= 1'b0;
        else        on_q <= en_q;
    end

    assign on   = on_q;
    assign gclk = lane_clk & on_q;
endmodule

// File: rtl/ccs_ctrl.sv
`timescale 1ns/1ps
module ccs_ctrl
    import ccs_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic cmd_use_usr,
    input  logic cmd_use_osc,
    input  logic cmd_reengage,
    input  logic cfg_pin_n,
    input  logic tap_rst,
    input  logic scheme_active,
    input  logic user_mode,
    input  logic rmt_upd_en,
    input  logic err_det_en,
    input  logic osc_ack,
    input  logic usr_ack,
    output logic osc_req,
    output logic usr_req,
    output logic osc_en,
    output logic src_usr,
    output logic switching,
    output logic reconfig_req,
    output logic ctl_restart,
    output logic cfg_pulse,
    output logic cfg_pin_mask
);
    localparam int PCW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        phase_t         phase;
        src_t           cur;
        src_t           tgt;
        logic           pend_v;
        src_t           pend;
        logic           osc_req;
        logic           usr_req;
        logic           osc_en;
        logic           rc_pend;
        logic           rc_req;
        logic           restart;
        logic           pas;
        logic [PCW-1:0] pcnt;
        logic           mask;
        logic           cfg_pulse;
        logic           pin_q;
    } ctl_t;

    ctl_t s_d, s_q;
    logic keep;
    logic new_cmd;
    logic old_ack;
    logic new_ack;

    always_comb begin
        s_d        = s_q;
        s_d.rc_req = 1'b0;
        s_d.restart = 1'b0;
        new_cmd    = cmd_use_osc | cmd_use_usr;
        keep       = !user_mode | rmt_upd_en | err_det_en | s_q.rc_pend;
        old_ack    = (s_q.tgt == SRC_USR) ? osc_ack : usr_ack;
        new_ack    = (s_q.tgt == SRC_USR) ? usr_ack : osc_ack;

        // command capture: last wins, oscillator wins a tie
        if (cmd_use_osc) begin
            s_d.pend_v = 1'b1;
            s_d.pend   = SRC_OSC;
        end else if (cmd_use_usr) begin
            s_d.pend_v = 1'b1;
            s_d.pend   = SRC_USR;
        end

        unique case (s_q.phase)
            PH_IDLE: begin
                if (s_q.pend_v) begin
                    if (s_q.pend == s_q.cur) begin
                        if (!new_cmd) s_d.pend_v = 1'b0;
                    end else if (s_q.pend == SRC_OSC || keep) begin
                        s_d.tgt   = s_q.pend;
                        s_d.phase = PH_DROP;
                        if (s_q.pend == SRC_USR) s_d.osc_req = 1'b0;
                        else                     s_d.usr_req = 1'b0;
                        if (!new_cmd) s_d.pend_v = 1'b0;
                    end
                end
            end
            PH_DROP: begin
                if (!old_ack) begin
                    s_d.phase = PH_RAISE;
                    if (s_q.tgt == SRC_USR) s_d.usr_req = 1'b1;
                    else                    s_d.osc_req = 1'b1;
                end
            end
            PH_RAISE: begin
                if (new_ack) begin
                    s_d.cur   = s_q.tgt;
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        // configuration pin edge, ignored while masked
        s_d.pin_q = cfg_pin_n;
        if (s_q.pin_q && !cfg_pin_n && !s_q.mask) s_d.rc_req = 1'b1;

        // re-engage handling
        if (cmd_reengage) begin
            s_d.pcnt = PCW'(PULSE_LEN);
            s_d.pas  = !scheme_active;
            if (scheme_active) begin
                s_d.restart = 1'b1;
                s_d.rc_req  = 1'b1;
            end
        end else if (tap_rst) begin
            s_d.pcnt = '0;
        end else if (s_q.pcnt != '0) begin
            s_d.pcnt = s_q.pcnt - 1'b1;
        end
        s_d.mask      = (s_d.pcnt != '0);
        s_d.cfg_pulse = s_d.mask && s_d.pas;

        if (!user_mode) s_d.rc_pend = 1'b0;
        if (s_d.rc_req) s_d.rc_pend = 1'b1;

        s_d.osc_en = keep | (s_d.phase != PH_IDLE);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_RAISE;
            s_q.cur     <= SRC_OSC;
            s_q.tgt     <= SRC_OSC;
            s_q.pend    <= SRC_OSC;
            s_q.osc_req <= 1'b1;
            s_q.osc_en  <= 1'b1;
            s_q.pin_q   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign osc_req      = s_q.osc_req;
    assign usr_req      = s_q.usr_req;
    assign osc_en       = s_q.osc_en;
    assign src_usr      = (s_q.cur == SRC_USR);
    assign switching    = (s_q.phase != PH_IDLE);
    assign reconfig_req = s_q.rc_req;
    assign ctl_restart  = s_q.restart;
    assign cfg_pulse    = s_q.cfg_pulse;
    assign cfg_pin_mask = s_q.mask;

    assert_keep_osc_R6: assert property (
        @(posedge clk) disable iff (!por_n)
        (!user_mode || rmt_upd_en || err_det_en) |=> osc_en
    );

    assert_pin_masked_R9: assert property (
        @(posedge clk) disable iff (!por_n)
        (cfg_pin_mask && $fell(cfg_pin_n) && !cmd_reengage) |=> !reconfig_req
    );

    assert_commit_at_end_R11: assert property (
        @(posedge clk) disable iff (!por_n)
        !$stable(src_usr) |-> $past(s_q.phase == PH_RAISE)
    );

    assert_passive_pulse_R8: assert property (
        @(posedge clk) disable iff (!por_n)
        $rose(cfg_pulse) |-> $past(cmd_reengage && !scheme_active)
    );

    assert_restart_active_R7: assert property (
        @(posedge clk) disable iff (!por_n)
        ctl_restart |-> $past(cmd_reengage && scheme_active)
    );
endmodule

// File: rtl/cfg_clk_source_sel.sv
`timescale 1ns/1ps
module cfg_clk_source_sel
    import ccs_pkg::*;
#(
    parameter int PULSE_LEN   = 8,
    parameter int USR_TAIL    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic ctl_clk,
    input  logic por_n,
    input  logic osc_clk,
    input  logic usr_clk,
    input  logic cmd_use_usr,
    input  logic cmd_use_osc,
    input  logic cmd_reengage,
    input  logic cfg_pin_n,
    input  logic tap_rst,
    input  logic scheme_active,
    input  logic user_mode,
    input  logic rmt_upd_en,
    input  logic err_det_en,
    output logic sel_clk,
    output logic data_clk,
    output logic osc_en,
    output logic src_usr,
    output logic switching,
    output logic reconfig_req,
    output logic ctl_restart,
    output logic cfg_pulse,
    output logic cfg_pin_mask
);
    logic [LANES-1:0] lane_clk;
    logic [LANES-1:0] lane_req;
    logic [LANES-1:0] lane_on;
    logic [LANES-1:0] lane_gclk;
    logic [LANES-1:0] lane_ack;
    logic             osc_req;
    logic             usr_req;
    logic             div_q;

    assign lane_clk[LANE_OSC] = osc_clk;
    assign lane_clk[LANE_USR] = usr_clk;
    assign lane_req[LANE_OSC] = osc_req;
    assign lane_req[LANE_USR] = usr_req;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            ccs_lane #(
                .HOLD  ((i == LANE_USR) ? USR_TAIL : 0),
                .STAGES(SYNC_STAGES)
            ) u_lane (
                .lane_clk(lane_clk[i]),
                .por_n   (por_n),
                .req     (lane_req[i]),
                .on      (lane_on[i]),
                .gclk    (lane_gclk[i])
            );
        end
    endgenerate

    assign sel_clk = |lane_gclk;

    ccs_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_ack (
        .clk  (ctl_clk),
        .rst_n(por_n),
        .d    (lane_on),
        .q    (lane_ack)
    );

    ccs_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk          (ctl_clk),
        .por_n        (por_n),
        .cmd_use_usr  (cmd_use_usr),
        .cmd_use_osc  (cmd_use_osc),
        .cmd_reengage (cmd_reengage),
        .cfg_pin_n    (cfg_pin_n),
        .tap_rst      (tap_rst),
        .scheme_active(scheme_active),
        .user_mode    (user_mode),
        .rmt_upd_en   (rmt_upd_en),
        .err_det_en   (err_det_en),
        .osc_ack      (lane_ack[LANE_OSC]),
        .usr_ack      (lane_ack[LANE_USR]),
        .osc_req      (osc_req),
        .usr_req      (usr_req),
        .osc_en       (osc_en),
        .src_usr      (src_usr),
        .switching    (switching),
        .reconfig_req (reconfig_req),
        .ctl_restart  (ctl_restart),
        .cfg_pulse    (cfg_pulse),
        .cfg_pin_mask (cfg_pin_mask)
    );

    always_ff @(posedge sel_clk or negedge por_n) begin
        if (!por_n) div_q <= 1'b0;
        else        div_q <= ~div_q;
    end
    assign data_clk = div_q;

    assert_lanes_exclusive_R11: assert property (
        @(posedge ctl_clk) disable iff (!por_n)
        !(lane_ack[LANE_OSC] && lane_ack[LANE_USR])
    );
endmodule

// File: tb/sim_cfg_clk_source_sel.sv
`timescale 1ns/1ps
module sim_cfg_clk_source_sel;
    localparam int PULSE_LEN = 8;
    localparam int USR_TAIL  = 10;
    // {user_mode, rmt_upd_en, err_det_en, expected osc_en}
    localparam logic [3:0] VEC [6] = '{4'b0001, 4'b1000, 4'b1101,
                                      4'b1011, 4'b1111, 4'b0101};

    logic ctl_clk = 1'b0, osc_clk = 1'b0, usr_clk = 1'b0, usr_run = 1'b1;
    logic por_n = 1'b0;
    logic cmd_use_usr = 1'b0, cmd_use_osc = 1'b0, cmd_reengage = 1'b0;
    logic cfg_pin_n = 1'b1, tap_rst = 1'b0, scheme_active = 1'b1;
    logic user_mode = 1'b0, rmt_upd_en = 1'b0, err_det_en = 1'b0;
    logic sel_clk, data_clk, osc_en, src_usr, switching;
    logic reconfig_req, ctl_restart, cfg_pulse, cfg_pin_mask;
    int   checks = 0, errors = 0;
    int   sel_cnt = 0, osc_cnt = 0, usr_cnt = 0, dat_cnt = 0;
    bit   done = 1'b0;

    always #2.5 ctl_clk = ~ctl_clk;
    always #4   osc_clk = ~osc_clk;
    always begin
        #7;
        if (usr_run || usr_clk) usr_clk = ~usr_clk;
    end
    always @(posedge sel_clk)  sel_cnt++;
    always @(posedge osc_clk)  osc_cnt++;
    always @(posedge usr_clk)  usr_cnt++;
    always @(posedge data_clk) dat_cnt++;

    cfg_clk_source_sel #(.PULSE_LEN(PULSE_LEN), .USR_TAIL(USR_TAIL)) u0 (
        .ctl_clk(ctl_clk), .por_n(por_n), .osc_clk(osc_clk), .usr_clk(usr_clk),
        .cmd_use_usr(cmd_use_usr), .cmd_use_osc(cmd_use_osc),
        .cmd_reengage(cmd_reengage), .cfg_pin_n(cfg_pin_n), .tap_rst(tap_rst),
        .scheme_active(scheme_active), .user_mode(user_mode),
        .rmt_upd_en(rmt_upd_en), .err_det_en(err_det_en),
        .sel_clk(sel_clk), .data_clk(data_clk), .osc_en(osc_en),
        .src_usr(src_usr), .switching(switching), .reconfig_req(reconfig_req),
        .ctl_restart(ctl_restart), .cfg_pulse(cfg_pulse),
        .cfg_pin_mask(cfg_pin_mask)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge ctl_clk);
    endtask

    task automatic cmd(input bit o, input bit u, input bit r);
        cmd_use_osc = o; cmd_use_usr = u; cmd_reengage = r;
        @(negedge ctl_clk);
        cmd_use_osc = 1'b0; cmd_use_usr = 1'b0; cmd_reengage = 1'b0;
    endtask

    task automatic settle(input string tag);
        tick(4);
        for (int i = 0; i < 400 && switching; i++) tick(1);
        chk(switching == 1'b0, tag, switching, 0);
    endtask

    task automatic rate(input string tag, input bit want_usr);
        int s, r;
        sel_cnt = 0; osc_cnt = 0; usr_cnt = 0; dat_cnt = 0;
        tick(100);
        s = sel_cnt;
        r = want_usr ? usr_cnt : osc_cnt;
        chk((s - r) <= 1 && (r - s) <= 1, tag, s, r);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        int mcnt, rcnt, pcnt, xcnt, ucnt;
        tick(5);
        por_n = 1'b1;
        settle("R1 initial changeover");
        chk(src_usr == 1'b0, "R1 reset source", src_usr, 0);
        rate("R1 sel_clk follows oscillator", 1'b0);

        // R6: keep conditions, walked from the table
        for (int i = 0; i < 6; i++) begin
            {user_mode, rmt_upd_en, err_det_en} = VEC[i][3:1];
            tick(1);
            chk(osc_en == VEC[i][0], "R6 osc_en vector", osc_en, VEC[i][0]);
        end

        // R3: user-clock request held while oscillator is not kept
        user_mode = 1'b1; rmt_upd_en = 1'b0; err_det_en = 1'b0;
        tick(1);
        cmd(1'b0, 1'b1, 1'b0);
        tick(30);
        chk(src_usr == 1'b0 && switching == 1'b0, "R3 request held", src_usr, 0);
        err_det_en = 1'b1;
        settle("R3 changeover after keep");
        chk(src_usr == 1'b1, "R2 committed user clock", src_usr, 1);
        rate("R2 sel_clk follows user clock", 1'b1);

        // R9 unmasked pin edge; R5 pin and test reset keep selection
        cfg_pin_n = 1'b0;
        tick(1);
        chk(reconfig_req == 1'b1, "R9 unmasked pin request", reconfig_req, 1);
        tick(1);
        chk(reconfig_req == 1'b0, "R9 request one cycle", reconfig_req, 0);
        cfg_pin_n = 1'b1;
        tap_rst = 1'b1; tick(1); tap_rst = 1'b0;
        tick(20);
        chk(src_usr == 1'b1 && switching == 1'b0, "R5 selection kept", src_usr, 1);
        err_det_en = 1'b0;
        tick(1); tick(1);
        chk(osc_en == 1'b1, "R6 pending reconfig keeps oscillator", osc_en, 1);
        user_mode = 1'b0; tick(1); user_mode = 1'b1;
        err_det_en = 1'b1;

        // R4: return stalls while user clock is stopped
        usr_run = 1'b0;
        tick(5);
        cmd(1'b1, 1'b0, 1'b0);
        tick(100);
        chk(src_usr == 1'b1, "R4 stalled source", src_usr, 1);
        chk(switching == 1'b1, "R4 stalled changeover", switching, 1);
        cmd(1'b0, 1'b1, 1'b0);
        tick(1);
        cmd(1'b1, 1'b0, 1'b0);      // R10: last command is oscillator
        usr_cnt = 0;
        usr_run = 1'b1;
        tick(1);
        for (int i = 0; i < 400 && switching; i++) tick(1);
        ucnt = usr_cnt;
        chk(ucnt >= USR_TAIL, "R4 user edges before commit", ucnt, USR_TAIL);
        chk(src_usr == 1'b0, "R4 committed oscillator", src_usr, 0);
        tick(30);
        chk(src_usr == 1'b0 && switching == 1'b0, "R10 last command osc", src_usr, 0);

        // R10: commands during a changeover, last wins user clock
        cmd(1'b0, 1'b1, 1'b0);
        tick(2);
        cmd(1'b1, 1'b0, 1'b0);
        cmd(1'b0, 1'b1, 1'b0);
        settle("R10 changeover end");
        tick(30);
        chk(src_usr == 1'b1 && switching == 1'b0, "R10 last command usr", src_usr, 1);
        cmd(1'b1, 1'b1, 1'b0);
        settle("R10 tie changeover end");
        tick(30);
        chk(src_usr == 1'b0, "R10 tie goes to oscillator", src_usr, 0);

        // R7, R9: active re-engage
        scheme_active = 1'b1;
        cmd(1'b0, 1'b0, 1'b1);
        chk(ctl_restart == 1'b1, "R7 restart pulse", ctl_restart, 1);
        chk(reconfig_req == 1'b1, "R7 reconfig pulse", reconfig_req, 1);
        mcnt = cfg_pin_mask; rcnt = 0; pcnt = cfg_pulse; xcnt = 0;
        cfg_pin_n = 1'b0;
        for (int i = 0; i < 15; i++) begin
            tick(1);
            mcnt += cfg_pin_mask; rcnt += reconfig_req;
            pcnt += cfg_pulse; xcnt += ctl_restart;
        end
        cfg_pin_n = 1'b1;
        chk(xcnt == 0, "R7 restart one cycle", xcnt, 0);
        chk(mcnt == PULSE_LEN, "R9 mask length", mcnt, PULSE_LEN);
        chk(rcnt == 0, "R9 masked pin ignored", rcnt, 0);
        chk(pcnt == 0, "R8 no pulse in active scheme", pcnt, 0);

        // R8: passive re-engage
        tick(2);
        scheme_active = 1'b0;
        cmd(1'b0, 1'b0, 1'b1);
        pcnt = cfg_pulse; rcnt = reconfig_req; xcnt = ctl_restart;
        for (int i = 0; i < 15; i++) begin
            tick(1);
            pcnt += cfg_pulse; rcnt += reconfig_req; xcnt += ctl_restart;
        end
        chk(pcnt == PULSE_LEN, "R8 passive pulse length", pcnt, PULSE_LEN);
        chk(rcnt == 0 && xcnt == 0, "R8 no request or restart", rcnt + xcnt, 0);

        // R13: test reset aborts re-engage handling
        cmd(1'b0, 1'b0, 1'b1);
        tick(2);
        tap_rst = 1'b1; tick(1); tap_rst = 1'b0;
        chk(cfg_pin_mask == 1'b0 && cfg_pulse == 1'b0, "R13 abort",
            cfg_pin_mask + cfg_pulse, 0);

        // R12: divided data clock
        sel_cnt = 0; dat_cnt = 0;
        tick(100);
        chk((sel_cnt - 2*dat_cnt) <= 2 && (2*dat_cnt - sel_cnt) <= 2,
            "R12 data clock half rate", 2*dat_cnt, sel_cnt);

        // R1: power-on reset clears a user selection
        cmd(1'b0, 1'b1, 1'b0);
        settle("R1 prepare user selection");
        chk(src_usr == 1'b1, "R1 user selected before reset", src_usr, 1);
        #1 por_n = 1'b0;
        #1 chk(src_usr == 1'b0, "R1 reset clears selection", src_usr, 0);
        tick(3);
        por_n = 1'b1;
        settle("R1 after second reset");
        chk(src_usr == 1'b0, "R1 oscillator after reset", src_usr, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule